// File: doc/BRIEF.md
# Block-Crossing Load Splitter and Merger

This unit sits between a load queue and a data cache with two read lanes. It takes one load (address, byte size, load-linked flag) and decides whether the bytes cross a cache-block boundary. A load that fits inside one block goes out as a single read on the low lane. A crossing load goes out as two reads in the same cycle. The low lane reads from the original address up to the end of the block. The high lane reads the rest, starting at the next block base. Each read that the cache accepts uses one lane for that cycle.

The unit counts the responses still due. It places each one into a single result buffer, with high-part bytes placed after the low-part bytes. It emits one writeback for the whole load once the last response has arrived. Failure is all-or-nothing. If the cache is flagged blocked, or it refuses the low read, nothing is kept and a retry request is raised. If the cache takes the low read but refuses the high read, the load is marked for replay: the one response still due is drained without a writeback, and a retry request is raised. A squash discards the load in flight, and any late responses are swallowed.

Top module: `ldsplit_unit`

## Requirements
- R1: After reset the unit is idle: `req_ready` is 1, and `wb_valid`, `retry_req`, `blocked_evt`, `lo_rd_valid` and `hi_rd_valid` are 0.
- R2: With offset = `req_addr` mod BLK_BYTES, a load without the load-linked flag is split when offset + size > BLK_BYTES. The low lane then reads `req_addr` with size BLK_BYTES - offset. The high lane reads the next block base (`req_addr` with the offset bits cleared, plus BLK_BYTES) with the remaining size. A non-split load drives only the low lane, with the full size. All lane outputs are combinational in the issue cycle.
- R3: A load with `req_llsc` = 1 is never split. It goes out whole on the low lane, and `hi_rd_valid` stays 0.
- R4: If `cache_blocked` is 1 in the issue cycle, neither lane is driven. `blocked_evt` and `retry_req` each pulse for one cycle in the next cycle, and `req_ready` stays 1.
- R5: If the low read is refused (`lo_rd_accept` = 0), the high lane is not driven, `retry_req` pulses in the next cycle, the load is dropped with no writeback, and `req_ready` stays 1.
- R6: If the low read is accepted but the high read is refused, `retry_req` pulses in the next cycle. `req_ready` stays 0 until the single remaining response arrives. That response produces no writeback, and `req_ready` returns to 1 in the cycle after it.
- R7: An accepted load gives exactly one `wb_valid` pulse. The pulse appears in the cycle after its last response (the first response for a non-split load, the second for a split load), with `wb_addr` and `wb_size` equal to the original address and size. No writeback follows the first response of a split load.
- R8: `wb_data` byte i (byte 0 in bits 7:0) is, for i < low size, byte i of the low response. For low size <= i < size it is byte i - low size of the high response. Bytes at or above size are 0. For a non-split load the low size equals the size.
- R9: The two responses of a split load (`rsp_part` 0 = low, 1 = high) may arrive in either order, and the merged result is the same.
- R10: A `squash` pulse while a load is in flight suppresses its writeback. Responses still due are discarded, and `req_ready` returns to 1 in the cycle after the last of them. A squash while idle has no effect.
- R11: `req_ready` is 0 from the cycle after an accepted issue until the load completes, and no lane is driven while `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Unit idle and able to issue |
| req_addr | input | ADDR_W | Load byte address |
| req_size | input | SZ_W | Load size in bytes, 1..MAXB |
| req_llsc | input | 1 | Load-linked access, never split |
| squash | input | 1 | Discard the load in flight |
| cache_blocked | input | 1 | Cache signalled blocked; no issue this cycle |
| lo_rd_valid | output | 1 | Low-lane read request |
| lo_rd_addr | output | ADDR_W | Low-lane address |
| lo_rd_size | output | SZ_W | Low-lane byte count |
| lo_rd_accept | input | 1 | Cache takes the low-lane read |
| hi_rd_valid | output | 1 | High-lane read request |
| hi_rd_addr | output | ADDR_W | High-lane address (next block base) |
| hi_rd_size | output | SZ_W | High-lane byte count |
| hi_rd_accept | input | 1 | Cache takes the high-lane read |
| rsp_valid | input | 1 | Read response present |
| rsp_part | input | 1 | 0 = low part, 1 = high part |
| rsp_data | input | 8*MAXB | Response bytes, right-aligned |
| wb_valid | output | 1 | One-cycle writeback of the whole load |
| wb_addr | output | ADDR_W | Original load address |
| wb_size | output | SZ_W | Original load size |
| wb_data | output | 8*MAXB | Merged load bytes |
| retry_req | output | 1 | One-cycle request to replay from the queue |
| blocked_evt | output | 1 | One-cycle mark of an issue lost to a blocked cache |

## Verification
A wrong outstanding count shows up at the ports one response late or one response early. Either a split load writes back after only its first response, or it never writes back and `req_ready` stays low for good. A corrupt merge offset shows up in `wb_data` in the same cycle as the writeback, as bytes from the wrong response or in shifted positions. For this reason the directed cases use offsets where the low part is one byte, most of the load, or exactly fills the block. A lost replay or squash mark appears as a spurious `wb_valid` in the cycle after the last drained response.

// File: rtl/ldsplit_pkg.sv
package ldsplit_pkg;

    // Controller phase
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_DRAIN = 2'd2
    } ldsplit_state_t;

    // Result of the issue attempt in one cycle
    typedef enum logic [2:0] {
        OUT_NONE    = 3'd0,
        OUT_BLOCKED = 3'd1,
        OUT_REJ_LO  = 3'd2,
        OUT_REJ_HI  = 3'd3,
        OUT_OK      = 3'd4
    } ldsplit_issue_t;

    // Responses still due for a load of one or two parts
    function automatic logic [1:0] parts_due(input logic two_part);
        return two_part ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/ldsplit_calc.sv
module ldsplit_calc #(
    parameter int ADDR_W    = 32,
    parameter int BLK_BYTES = 64,
    parameter int MAXB      = 8,
    parameter int SZ_W      = $clog2(MAXB) + 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SZ_W-1:0]   size,
    input  logic              llsc,
    output logic              two_part,
    output logic [SZ_W-1:0]   lo_size,
    output logic [ADDR_W-1:0] hi_addr,
    output logic [SZ_W-1:0]   hi_size
);
    localparam int OFF_W = $clog2(BLK_BYTES);
    localparam int CW    = ((OFF_W > SZ_W) ? OFF_W : SZ_W) + 2;

    logic [CW-1:0] off_c, sz_c, blk_c, lo_c, hi_c;
    logic          crosses;

    always_comb begin
        off_c   = CW'(addr[OFF_W-1:0]);
        sz_c    = CW'(size);
        blk_c   = CW'(BLK_BYTES);
        crosses = (off_c + sz_c) > blk_c;
        // load-linked accesses stay whole
        two_part = crosses && !llsc;
        lo_c     = two_part ? (blk_c - off_c) : sz_c;
        hi_c     = sz_c - lo_c;
        lo_size  = SZ_W'(lo_c);
        hi_size  = SZ_W'(hi_c);
        hi_addr  = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}} + ADDR_W'(BLK_BYTES);
    end
endmodule

// File: rtl/ldsplit_issue.sv
module ldsplit_issue
    import ldsplit_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SZ_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_ready,
    input  logic              req_llsc,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              cache_blocked,
    input  logic              two_part,
    input  logic [SZ_W-1:0]   lo_size,
    input  logic [ADDR_W-1:0] hi_addr,
    input  logic [SZ_W-1:0]   hi_size,
    output logic              lo_rd_valid,
    output logic [ADDR_W-1:0] lo_rd_addr,
    output logic [SZ_W-1:0]   lo_rd_size,
    input  logic              lo_rd_accept,
    output logic              hi_rd_valid,
    output logic [ADDR_W-1:0] hi_rd_addr,
    output logic [SZ_W-1:0]   hi_rd_size,
    input  logic              hi_rd_accept,
    output ldsplit_issue_t    outcome
);
    logic fire;

    always_comb begin
        fire        = req_valid && req_ready;
        lo_rd_valid = fire && !cache_blocked;
        lo_rd_addr  = req_addr;
        lo_rd_size  = lo_size;
        // the high part is only offered once the low part is taken
        hi_rd_valid = lo_rd_valid && lo_rd_accept && two_part;
        hi_rd_addr  = hi_addr;
        hi_rd_size  = hi_size;

        if (!fire)                          outcome = OUT_NONE;
        else if (cache_blocked)             outcome = OUT_BLOCKED;
        else if (!lo_rd_accept)             outcome = OUT_REJ_LO;
        else if (two_part && !hi_rd_accept) outcome = OUT_REJ_HI;
        else                                outcome = OUT_OK;
    end

    // R6
    hi_after_lo_chk: assert property (@(posedge clk) disable iff (rst)
        hi_rd_valid |-> (lo_rd_valid && lo_rd_accept));

    // R3
    ll_whole_chk: assert property (@(posedge clk) disable iff (rst)
        (req_llsc && lo_rd_valid) |-> !hi_rd_valid);

    // R4
    blocked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cache_blocked |-> !lo_rd_valid);

    // R11
    issue_idle_chk: assert property (@(posedge clk) disable iff (rst)
        lo_rd_valid |-> req_ready);
endmodule

// File: rtl/ldsplit_merge.sv
module ldsplit_merge #(
    parameter int MAXB = 8,
    parameter int SZ_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              wr_en,
    input  logic              wr_part,
    input  logic [8*MAXB-1:0] wr_data,
    input  logic [SZ_W-1:0]   lo_size,
    input  logic [SZ_W-1:0]   tot_size,
    output logic [8*MAXB-1:0] merged
);
    localparam int DW = 8 * MAXB;

    logic [DW-1:0]   buf_q, buf_n, shifted;
    logic [SZ_W-1:0] first_b, end_b;

    always_comb begin
        first_b = wr_part ? lo_size : '0;
        end_b   = wr_part ? tot_size : lo_size;
        shifted = wr_data << {first_b, 3'b000};
    end

    for (genvar g = 0; g < MAXB; g++) begin : g_byte
        logic hit;
        always_comb begin
            hit = (SZ_W'(g) >= first_b) && (SZ_W'(g) < end_b);
            if (clear)
                buf_n[8*g +: 8] = 8'h00;
            else if (wr_en && hit)
                buf_n[8*g +: 8] = shifted[8*g +: 8];
            else
                buf_n[8*g +: 8] = buf_q[8*g +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) buf_q <= '0;
        else     buf_q <= buf_n;
    end

    assign merged = buf_q;

    // R8
    hi_write_split_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_part) |-> (lo_size < tot_size));

    // R8
    no_clear_collide_chk: assert property (@(posedge clk) disable iff (rst)
        clear |-> !wr_en);
endmodule

// File: rtl/ldsplit_ctrl.sv
module ldsplit_ctrl
    import ldsplit_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SZ_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  ldsplit_issue_t    outcome,
    input  logic              two_part,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SZ_W-1:0]   req_size,
    input  logic [SZ_W-1:0]   lo_size,
    input  logic              rsp_valid,
    input  logic              squash,
    output logic              req_ready,
    output logic              buf_clear,
    output logic              buf_wr,
    output logic [SZ_W-1:0]   lat_lo,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [SZ_W-1:0]   wb_size,
    output logic              retry_req,
    output logic              blocked_evt
);
    ldsplit_state_t    state_q, state_n;
    logic [1:0]        cnt_q, cnt_n;
    logic              wb_n, retry_n, blk_n, load_n;
    logic [ADDR_W-1:0] addr_q;
    logic [SZ_W-1:0]   size_q, lo_q;

    always_comb begin
        state_n   = state_q;
        cnt_n     = cnt_q;
        wb_n      = 1'b0;
        retry_n   = 1'b0;
        blk_n     = 1'b0;
        load_n    = 1'b0;
        buf_clear = 1'b0;
        buf_wr    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                unique case (outcome)
                    OUT_BLOCKED: begin
                        retry_n = 1'b1;
                        blk_n   = 1'b1;
                    end
                    OUT_REJ_LO: retry_n = 1'b1;
                    OUT_REJ_HI: begin
                        // low part is in flight: drain it, replay the load
                        retry_n = 1'b1;
                        state_n = ST_DRAIN;
                        cnt_n   = 2'd1;
                    end
                    OUT_OK: begin
                        state_n   = ST_WAIT;
                        cnt_n     = parts_due(two_part);
                        buf_clear = 1'b1;
                        load_n    = 1'b1;
                    end
                    default: ;
                endcase
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    buf_wr = !squash;
                    cnt_n  = cnt_q - 2'd1;
                    if (cnt_q == 2'd1) begin
                        state_n = ST_IDLE;
                        wb_n    = !squash;
                    end else if (squash) begin
                        state_n = ST_DRAIN;
                    end
                end else if (squash) begin
                    state_n = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (rsp_valid) begin
                    cnt_n = cnt_q - 2'd1;
                    if (cnt_q == 2'd1) state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            cnt_q       <= 2'd0;
            wb_valid    <= 1'b0;
            retry_req   <= 1'b0;
            blocked_evt <= 1'b0;
            addr_q      <= '0;
            size_q      <= '0;
            lo_q        <= '0;
        end else begin
            state_q     <= state_n;
            cnt_q       <= cnt_n;
            wb_valid    <= wb_n;
            retry_req   <= retry_n;
            blocked_evt <= blk_n;
            if (load_n) begin
                addr_q <= req_addr;
                size_q <= req_size;
                lo_q   <= lo_size;
            end
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign lat_lo    = lo_q;
    assign wb_addr   = addr_q;
    assign wb_size   = size_q;

    // R7
    wb_after_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> $past(rsp_valid));

    // R7
    wb_single_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid |=> !wb_valid);

    // R10
    squash_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (squash && !req_ready) |=> !wb_valid);

    // R4
    blocked_retry_chk: assert property (@(posedge clk) disable iff (rst)
        blocked_evt |-> retry_req);

    // R11
    count_live_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |-> (cnt_q != 2'd0));
endmodule

// File: rtl/ldsplit_unit.sv
module ldsplit_unit
    import ldsplit_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BLK_BYTES = 64,
    parameter int MAXB      = 8,
    parameter int SZ_W      = $clog2(MAXB) + 1,
    parameter int DW        = 8 * MAXB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SZ_W-1:0]   req_size,
    input  logic              req_llsc,
    input  logic              squash,
    input  logic              cache_blocked,
    output logic              lo_rd_valid,
    output logic [ADDR_W-1:0] lo_rd_addr,
    output logic [SZ_W-1:0]   lo_rd_size,
    input  logic              lo_rd_accept,
    output logic              hi_rd_valid,
    output logic [ADDR_W-1:0] hi_rd_addr,
    output logic [SZ_W-1:0]   hi_rd_size,
    input  logic              hi_rd_accept,
    input  logic              rsp_valid,
    input  logic              rsp_part,
    input  logic [DW-1:0]     rsp_data,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [SZ_W-1:0]   wb_size,
    output logic [DW-1:0]     wb_data,
    output logic              retry_req,
    output logic              blocked_evt
);
    logic              two_part;
    logic [SZ_W-1:0]   lo_size, hi_size, lat_lo;
    logic [ADDR_W-1:0] hi_addr;
    ldsplit_issue_t    outcome;
    logic              buf_clear, buf_wr;

    ldsplit_calc #(
        .ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES), .MAXB(MAXB), .SZ_W(SZ_W)
    ) u_calc (
        .addr(req_addr), .size(req_size), .llsc(req_llsc),
        .two_part(two_part), .lo_size(lo_size),
        .hi_addr(hi_addr), .hi_size(hi_size)
    );

    ldsplit_issue #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_issue (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_llsc(req_llsc),
        .req_addr(req_addr), .cache_blocked(cache_blocked),
        .two_part(two_part), .lo_size(lo_size),
        .hi_addr(hi_addr), .hi_size(hi_size),
        .lo_rd_valid(lo_rd_valid), .lo_rd_addr(lo_rd_addr),
        .lo_rd_size(lo_rd_size), .lo_rd_accept(lo_rd_accept),
        .hi_rd_valid(hi_rd_valid), .hi_rd_addr(hi_rd_addr),
        .hi_rd_size(hi_rd_size), .hi_rd_accept(hi_rd_accept),
        .outcome(outcome)
    );

    ldsplit_ctrl #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .outcome(outcome), .two_part(two_part),
        .req_addr(req_addr), .req_size(req_size), .lo_size(lo_size),
        .rsp_valid(rsp_valid), .squash(squash),
        .req_ready(req_ready), .buf_clear(buf_clear), .buf_wr(buf_wr),
        .lat_lo(lat_lo), .wb_valid(wb_valid), .wb_addr(wb_addr),
        .wb_size(wb_size), .retry_req(retry_req), .blocked_evt(blocked_evt)
    );

    ldsplit_merge #(.MAXB(MAXB), .SZ_W(SZ_W)) u_merge (
        .clk(clk), .rst(rst),
        .clear(buf_clear), .wr_en(buf_wr), .wr_part(rsp_part),
        .wr_data(rsp_data), .lo_size(lat_lo), .tot_size(wb_size),
        .merged(wb_data)
    );
endmodule

// File: tb/ldsplit_unit_tb.sv
module ldsplit_unit_tb;
    localparam int ADDR_W = 32;
    localparam int BLK    = 64;
    localparam int MAXB   = 8;
    localparam int SZ_W   = 4;
    localparam int DW     = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic              req_valid = 0, req_llsc = 0, squash = 0, cache_blocked = 0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [SZ_W-1:0]   req_size = '0;
    logic              lo_rd_accept = 0, hi_rd_accept = 0;
    logic              rsp_valid = 0, rsp_part = 0;
    logic [DW-1:0]     rsp_data = '0;
    logic              req_ready, lo_rd_valid, hi_rd_valid, wb_valid, retry_req, blocked_evt;
    logic [ADDR_W-1:0] lo_rd_addr, hi_rd_addr, wb_addr;
    logic [SZ_W-1:0]   lo_rd_size, hi_rd_size, wb_size;
    logic [DW-1:0]     wb_data;

    ldsplit_unit u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_llsc(req_llsc),
        .squash(squash), .cache_blocked(cache_blocked),
        .lo_rd_valid(lo_rd_valid), .lo_rd_addr(lo_rd_addr), .lo_rd_size(lo_rd_size),
        .lo_rd_accept(lo_rd_accept),
        .hi_rd_valid(hi_rd_valid), .hi_rd_addr(hi_rd_addr), .hi_rd_size(hi_rd_size),
        .hi_rd_accept(hi_rd_accept),
        .rsp_valid(rsp_valid), .rsp_part(rsp_part), .rsp_data(rsp_data),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_size(wb_size), .wb_data(wb_data),
        .retry_req(retry_req), .blocked_evt(blocked_evt)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] merge_exp(input logic [63:0] d0, input logic [63:0] d1,
                                              input int size, input int lo);
        logic [63:0] r = '0;
        for (int i = 0; i < MAXB; i++) begin
            if (i < size) begin
                if (i < lo) r[i*8 +: 8] = d0[i*8 +: 8];
                else        r[i*8 +: 8] = d1[(i-lo)*8 +: 8];
            end
        end
        return r;
    endfunction

    task automatic do_load(input logic [31:0] addr, input int size, input bit llsc,
                           input bit blk, input bit a0, input bit a1,
                           input bit sq, input bit rev);
        int off, lo, nparts;
        bit split;
        logic [31:0] hi_a;
        logic [63:0] d0, d1, exp_d;
        off   = int'(addr % BLK);
        split = !llsc && (off + size > BLK);
        lo    = split ? BLK - off : size;
        hi_a  = {addr[31:6], 6'b0} + 32'(BLK);
        d0    = {$urandom, $urandom};
        d1    = {$urandom, $urandom};

        @(negedge clk);
        req_valid = 1; req_addr = addr; req_size = SZ_W'(size); req_llsc = llsc;
        cache_blocked = blk; lo_rd_accept = a0; hi_rd_accept = a1;
        #1;
        chk(req_ready == 1, "R11 ready before issue", 64'(req_ready), 1);
        chk(lo_rd_valid == !blk, "R4 low lane valid", 64'(lo_rd_valid), 64'(!blk));
        if (!blk) begin
            chk(lo_rd_addr == addr, "R2 low addr", 64'(lo_rd_addr), 64'(addr));
            chk(lo_rd_size == SZ_W'(lo), "R2 low size", 64'(lo_rd_size), 64'(lo));
        end
        chk(hi_rd_valid == (!blk && a0 && split), "R2 R3 R5 high lane valid",
            64'(hi_rd_valid), 64'(!blk && a0 && split));
        if (!blk && a0 && split) begin
            chk(hi_rd_addr == hi_a, "R2 high addr", 64'(hi_rd_addr), 64'(hi_a));
            chk(hi_rd_size == SZ_W'(size - lo), "R2 high size", 64'(hi_rd_size),
                64'(size - lo));
        end
        if (llsc) chk(hi_rd_valid == 0, "R3 ll unsplit", 64'(hi_rd_valid), 0);

        @(negedge clk);
        req_valid = 0; cache_blocked = 0;
        if (blk || !a0) begin
            chk(retry_req == 1, blk ? "R4 retry" : "R5 retry", 64'(retry_req), 1);
            chk(blocked_evt == blk, "R4 blocked mark", 64'(blocked_evt), 64'(blk));
            chk(req_ready == 1, blk ? "R4 ready" : "R5 ready", 64'(req_ready), 1);
            chk(wb_valid == 0, "R5 no wb", 64'(wb_valid), 0);
            return;
        end
        chk(blocked_evt == 0, "R4 no blocked mark", 64'(blocked_evt), 0);
        if (split && !a1) begin
            chk(retry_req == 1, "R6 retry", 64'(retry_req), 1);
            chk(req_ready == 0, "R6 busy", 64'(req_ready), 0);
            rsp_valid = 1; rsp_part = 0; rsp_data = d0;
            @(negedge clk);
            rsp_valid = 0;
            chk(wb_valid == 0, "R6 no wb", 64'(wb_valid), 0);
            chk(req_ready == 1, "R6 ready after drain", 64'(req_ready), 1);
            return;
        end
        chk(retry_req == 0, "R7 no retry", 64'(retry_req), 0);
        chk(req_ready == 0, "R11 busy", 64'(req_ready), 0);
        if (sq) begin
            squash = 1;
            @(negedge clk);
            squash = 0;
        end
        nparts = split ? 2 : 1;
        exp_d  = merge_exp(d0, d1, size, lo);
        for (int k = 0; k < nparts; k++) begin
            bit p;
            p = split ? ((k == 0) ? rev : !rev) : 1'b0;
            rsp_valid = 1; rsp_part = p; rsp_data = p ? d1 : d0;
            @(negedge clk);
            rsp_valid = 0;
            if (k == nparts - 1 && !sq) begin
                chk(wb_valid == 1, "R7 wb after last", 64'(wb_valid), 1);
                chk(wb_addr == addr, "R7 wb addr", 64'(wb_addr), 64'(addr));
                chk(wb_size == SZ_W'(size), "R7 wb size", 64'(wb_size), 64'(size));
                chk(wb_data == exp_d, rev ? "R9 R8 merged data" : "R8 merged data",
                    wb_data, exp_d);
            end else begin
                chk(wb_valid == 0, sq ? "R10 no wb" : "R7 no early wb", 64'(wb_valid), 0);
            end
        end
        chk(req_ready == 1, sq ? "R10 ready" : "R11 ready after done", 64'(req_ready), 1);
        @(negedge clk);
        chk(wb_valid == 0, "R7 single pulse", 64'(wb_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1, "R1 ready", 64'(req_ready), 1);
        chk(wb_valid == 0 && retry_req == 0 && blocked_evt == 0, "R1 pulses idle",
            64'({wb_valid, retry_req, blocked_evt}), 0);
        chk(lo_rd_valid == 0 && hi_rd_valid == 0, "R1 lanes idle",
            64'({lo_rd_valid, hi_rd_valid}), 0);

        // R10 squash while idle has no effect
        squash = 1;
        @(negedge clk);
        squash = 0;
        chk(req_ready == 1 && wb_valid == 0, "R10 idle squash", 64'(req_ready), 1);

        // directed corners
        do_load(32'h0000_1038, 8, 0, 0, 1, 1, 0, 0); // fills block exactly
        do_load(32'h0000_103C, 8, 0, 0, 1, 1, 0, 0); // lo = 4
        do_load(32'h0000_1039, 8, 0, 0, 1, 1, 0, 1); // lo = 7, reversed
        do_load(32'h0000_107F, 8, 0, 0, 1, 1, 0, 0); // lo = 1
        do_load(32'hFFFF_FFFE, 4, 0, 0, 1, 1, 0, 1); // wraps address space
        do_load(32'h0000_203D, 6, 1, 0, 1, 1, 0, 0); // R3 load-linked crossing
        do_load(32'h0000_3000, 4, 0, 1, 1, 1, 0, 0); // R4 blocked
        do_load(32'h0000_303E, 4, 0, 0, 0, 1, 0, 0); // R5 low refused
        do_load(32'h0000_403E, 4, 0, 0, 1, 0, 0, 0); // R6 high refused
        do_load(32'h0000_503C, 8, 0, 0, 1, 1, 1, 0); // R10 squash split
        do_load(32'h0000_5010, 2, 0, 0, 1, 1, 1, 0); // R10 squash single
        do_load(32'h0000_6003, 3, 0, 0, 1, 1, 0, 0); // plain single

        for (int n = 0; n < 300; n++) begin
            logic [31:0] a;
            int sz;
            a  = $urandom;
            if ($urandom % 2 == 0) a[5:0] = 6'(56 + $urandom % 8);
            sz = 1 + int'($urandom % MAXB);
            do_load(a, sz, ($urandom % 8) == 0, ($urandom % 10) == 0,
                    ($urandom % 8) != 0, ($urandom % 6) != 0,
                    ($urandom % 10) == 0, ($urandom % 2) == 1);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule